// File: doc/BRIEF.md
# Clock Output Enable Controller

This block decides, for each of eight clock output lanes, whether the lane passes its clock, floats, or is driven low. Enable information comes from shared pads that configuration has turned into inputs: four individual enables, each tied to one even-numbered lane, and one control pad that can serve as a master enable or as a power-down request. Each of these functions has a configuration bit that picks its disabled state, either high impedance or driven low. A pad that configuration assigns to an input function stops acting as a clock output.

All pad inputs pass through a synchroniser clocked by the reference clock. Each lane's clock gate changes only on a reference edge where that lane's clock is sampled low, so that no shortened pulse reaches the pad. Power-down is the exception: the oscillator and PLLs stop, so the lanes close at once. When power-down is released, the lanes stay disabled for a programmable number of reference cycles while the PLLs settle. A global power-down indication goes to the oscillator, PLLs and dividers.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, every lane has gate_on, drive_en and force_low at 0, and pwr_down is 0.
- R2: Individual enable k (k = 0..3) is read from pad 7, 1, 3 or 5 and controls lane 0, 2, 4 or 6. It is active only when cfg_oe_pin[k] is 1. A 0 on the pad closes the controlled lane and a 1 opens it. A pad change becomes visible on gate_on after the third rising reference edge: two edges for synchronisation and one for the lane register.
- R3: A disabled lane shows the style of the function that disabled it. With style bit 0, drive_en and force_low are both 0 (high impedance). With style bit 1, drive_en and force_low are both 1. The style bit of enable k is cfg_oe_low[k].
- R4: When cfg_pin6 is 1, pad 6 is the master enable. A 0 on it disables every output lane, and the lanes take cfg_oem_low as their style, ahead of any individual enable style.
- R5: When cfg_pin6 is 2, pad 6 is an active-low power-down. pwr_down goes to 1 two edges after pad 6 falls. On the next edge every lane closes, even if its clock is high, and takes the cfg_pd_low style, ahead of any individual enable style. pwr_down is never 1 under any other role.
- R6: When power-down is released, pwr_down falls and the lanes stay disabled in the cfg_pd_low style for cfg_settle further edges. They open on edge cfg_settle+1 counted from the fall.
- R7: Outside power-down, a lane's gate_on opens or closes only on an edge where that lane's ch_clk is sampled 0. While ch_clk is held at 1, the gate keeps its state.
- R8: A pad that serves as an input keeps gate_on, drive_en and force_low at 0. Pads 7, 1, 3 and 5 are inputs when their enable is configured, and pad 6 is an input when cfg_pin6 is 1 or 2.
- R9: While a lane's gate is open, drive_en is 1 and force_low is 0 on that lane.
- R10: An unconfigured function has no effect. With cfg_oe_pin at 0 and cfg_pin6 at 0 or 3, all lanes open whatever the pad levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_clk | input | 8 | Per-lane generated clock, sampled to time the gate |
| pin_in | input | 8 | Receive value of each shared pad |
| cfg_oe_pin | input | 4 | Bit k turns on individual enable k |
| cfg_oe_low | input | 4 | Disabled style of individual enable k (1 = drive low) |
| cfg_pin6 | input | 2 | Pad 6 role: 0/3 clock, 1 master enable, 2 power-down |
| cfg_oem_low | input | 1 | Disabled style of the master enable |
| cfg_pd_low | input | 1 | Disabled style of power-down |
| cfg_settle | input | 8 | Hold-off cycles after power-down release |
| gate_on | output | 8 | Per-lane clock pass gate |
| drive_en | output | 8 | Per-lane pad output enable |
| force_low | output | 8 | Per-lane forced-low value |
| pwr_down | output | 1 | Global power-down to oscillator, PLLs and dividers |

## Verification
A lane register holding the wrong state shows on gate_on, drive_en and force_low on the edge it is loaded. The three outputs must agree with each other and with the style that wins by priority. A broken synchroniser or settle counter shows as an opening or closing one or more edges away from the expected count after the pad change or the fall of pwr_down. A gate that ignores the lane clock shows as a transition while ch_clk was high. The bench looks for each of these at the exact edge.

// File: rtl/cog_pkg.sv
package cog_pkg;
  localparam int NUM_CH  = 8;
  localparam int NUM_OE  = 4;
  localparam int CTL_PAD = 6;

  typedef enum logic [1:0] {
    ROLE_CLK     = 2'd0,
    ROLE_MASTER  = 2'd1,
    ROLE_PWRDN   = 2'd2,
    ROLE_CLK_ALT = 2'd3
  } ctl_role_e;

  // pad carrying individual enable k (controls lane 2k)
  function automatic int oe_pad_of(input int k);
    case (k)
      0:       return 7;
      1:       return 1;
      2:       return 3;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/cog_sync.sv
module cog_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  // pads reset to their pulled-up level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) st[s] <= '1;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cog_settle.sv
module cog_settle #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_active,
  input  logic [CW-1:0] cfg_settle,
  output logic          hold
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (pd_active)  cnt <= cfg_settle;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign hold = (cnt != '0);
endmodule

// File: rtl/cog_lane.sv
module cog_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic ch_clk,
  input  logic kill,
  input  logic want,
  input  logic dis_low,
  input  logic is_input,
  output logic gate_on,
  output logic drive_en,
  output logic force_low
);
  logic gate_q, drv_q, low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      drv_q  <= 1'b0;
      low_q  <= 1'b0;
    end else if (kill) begin
      // clocks are stopping: close without waiting for a low phase
      gate_q <= 1'b0;
      drv_q  <= dis_low;
      low_q  <= dis_low;
    end else if (!ch_clk) begin
      gate_q <= want;
      drv_q  <= want | dis_low;
      low_q  <= ~want & dis_low;
    end
  end

  assign gate_on   = gate_q & ~is_input;
  assign drive_en  = drv_q  & ~is_input;
  assign force_low = low_q  & ~is_input;
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
  import cog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   ch_clk,
  input  logic [NUM_CH-1:0]   pin_in,
  input  logic [NUM_OE-1:0]   cfg_oe_pin,
  input  logic [NUM_OE-1:0]   cfg_oe_low,
  input  logic [1:0]          cfg_pin6,
  input  logic                cfg_oem_low,
  input  logic                cfg_pd_low,
  input  logic [SETTLE_W-1:0] cfg_settle,
  output logic [NUM_CH-1:0]   gate_on,
  output logic [NUM_CH-1:0]   drive_en,
  output logic [NUM_CH-1:0]   force_low,
  output logic                pwr_down
);
  ctl_role_e           role;
  logic [NUM_CH-1:0]   pad_s;
  logic [NUM_CH-1:0]   in_role;
  logic [NUM_OE-1:0]   oe_ok;
  logic                pd_active, oem_ok, hold, stop_pd, run_ok;

  assign role = ctl_role_e'(cfg_pin6);

  cog_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pad_s)
  );

  assign pd_active = (role == ROLE_PWRDN)  & ~pad_s[CTL_PAD];
  assign oem_ok    = (role != ROLE_MASTER) |  pad_s[CTL_PAD];

  cog_settle #(.CW(SETTLE_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .pd_active(pd_active),
    .cfg_settle(cfg_settle), .hold(hold)
  );

  assign stop_pd  = pd_active | hold;
  assign run_ok   = ~stop_pd & oem_ok;
  assign pwr_down = pd_active;

  always_comb begin
    in_role = '0;
    for (int k = 0; k < NUM_OE; k++) begin
      oe_ok[k] = ~cfg_oe_pin[k] | pad_s[oe_pad_of(k)];
      if (cfg_oe_pin[k]) in_role[oe_pad_of(k)] = 1'b1;
    end
    if (role == ROLE_MASTER || role == ROLE_PWRDN) in_role[CTL_PAD] = 1'b1;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic want, dlow;
    if (i % 2 == 0) begin : g_oe
      assign want = run_ok & oe_ok[i/2];
      assign dlow = stop_pd ? cfg_pd_low : (!oem_ok ? cfg_oem_low : cfg_oe_low[i/2]);
    end else begin : g_free
      assign want = run_ok;
      assign dlow = stop_pd ? cfg_pd_low : cfg_oem_low;
    end

    cog_lane u_lane (
      .clk(clk), .rst_n(rst_n), .ch_clk(ch_clk[i]), .kill(pd_active),
      .want(want), .dis_low(dlow), .is_input(in_role[i]),
      .gate_on(gate_on[i]), .drive_en(drive_en[i]), .force_low(force_low[i])
    );
  end
endmodule

// File: rtl/cog_chk.sv
module cog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ch_clk,
  input logic [1:0] cfg_pin6,
  input logic [7:0] cfg_settle,
  input logic [7:0] gate_on,
  input logic [7:0] drive_en,
  input logic [7:0] force_low,
  input logic       pwr_down
);
  AST_PD_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (gate_on == 8'h00));                                    // R5
  AST_PD_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (cfg_pin6 == 2'd2));                                    // R5
  AST_OPEN_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_on & ~$past(gate_on) & $past(ch_clk)) == 8'h00));             // R7
  AST_CLOSE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwr_down) |-> ((~gate_on & $past(gate_on) & $past(ch_clk)) == 8'h00)); // R7
  AST_LOW_IS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((force_low & ~drive_en) == 8'h00));                                 // R3
  AST_OPEN_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_on & (~drive_en | force_low)) == 8'h00));                     // R9
  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwr_down) && cfg_settle != 8'd0) |=> (gate_on == 8'h00));    // R6
  AST_CTL_PAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pin6 == 2'd1 || cfg_pin6 == 2'd2) |-> (!gate_on[6] && !drive_en[6])); // R8
endmodule

bind clkout_gate_ctrl cog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch_clk(ch_clk), .cfg_pin6(cfg_pin6),
  .cfg_settle(cfg_settle), .gate_on(gate_on), .drive_en(drive_en),
  .force_low(force_low), .pwr_down(pwr_down)
);

// File: tb/clkout_gate_ctrl_test.sv
module clkout_gate_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ch_clk = 8'h00, pin_in = 8'hFF;
  logic [3:0] cfg_oe_pin = 4'h0, cfg_oe_low = 4'h0;
  logic [1:0] cfg_pin6 = 2'd0;
  logic       cfg_oem_low = 1'b0, cfg_pd_low = 1'b0;
  logic [7:0] cfg_settle = 8'd0;
  logic [7:0] gate_on, drive_en, force_low;
  logic       pwr_down;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  clkout_gate_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ch_clk(ch_clk), .pin_in(pin_in),
    .cfg_oe_pin(cfg_oe_pin), .cfg_oe_low(cfg_oe_low), .cfg_pin6(cfg_pin6),
    .cfg_oem_low(cfg_oem_low), .cfg_pd_low(cfg_pd_low), .cfg_settle(cfg_settle),
    .gate_on(gate_on), .drive_en(drive_en), .force_low(force_low), .pwr_down(pwr_down)
  );

  // oe_pin, oe_low, pin6, oem_low, pd_low, pads | exp gate, drive, low, pwr
  localparam int VW = 45;
  localparam logic [VW-1:0] VEC [12] = '{
    {4'b0000, 4'b0000, 2'd0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'hFF, 8'h00, 1'b0}, // R10
    {4'b1111, 4'b0000, 2'd0, 1'b0, 1'b0, 8'hFF, 8'h55, 8'h55, 8'h00, 1'b0}, // R8 R2
    {4'b1111, 4'b0000, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}, // R2 R3
    {4'b1111, 4'b1111, 2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h55, 8'h55, 1'b0}, // R3
    {4'b0101, 4'b0001, 2'd0, 1'b0, 1'b0, 8'h00, 8'h66, 8'h67, 8'h01, 1'b0}, // R3
    {4'b0000, 4'b0000, 2'd1, 1'b1, 1'b0, 8'h00, 8'h00, 8'hBF, 8'hBF, 1'b0}, // R4
    {4'b0001, 4'b0001, 2'd1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}, // R4
    {4'b0001, 4'b0001, 2'd1, 1'b0, 1'b0, 8'h40, 8'h3E, 8'h3F, 8'h01, 1'b0}, // R4 R9
    {4'b0000, 4'b0000, 2'd2, 1'b0, 1'b1, 8'h00, 8'h00, 8'hBF, 8'hBF, 1'b1}, // R5
    {4'b0001, 4'b0001, 2'd2, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1}, // R5
    {4'b0000, 4'b0000, 2'd2, 1'b0, 1'b0, 8'h40, 8'hBF, 8'hBF, 8'h00, 1'b0}, // R5 R9
    {4'b0000, 4'b0000, 2'd3, 1'b1, 1'b1, 8'h00, 8'hFF, 8'hFF, 8'h00, 1'b0}  // R10
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic restart(input logic [3:0] oep, input logic [3:0] oel, input logic [1:0] p6,
                         input logic oeml, input logic pdl, input logic [7:0] st, input logic [7:0] pads);
    rst_n = 1'b0;
    step(1);
    cfg_oe_pin = oep; cfg_oe_low = oel; cfg_pin6 = p6;
    cfg_oem_low = oeml; cfg_pd_low = pdl; cfg_settle = st;
    pin_in = pads; ch_clk = 8'h00;
    step(1);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    step(2);
    check(gate_on == 0 && drive_en == 0 && force_low == 0 && !pwr_down, "R1",
          {gate_on, drive_en, force_low, 7'd0, pwr_down}, 32'h0);
    rst_n = 1'b1;
    #0;
    check(gate_on == 0 && drive_en == 0 && force_low == 0, "R1 release",
          {gate_on, drive_en, force_low, 8'h0}, 32'h0);

    for (int v = 0; v < 12; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      restart(e[44:41], e[40:37], e[36:35], e[34], e[33], 8'd0, e[32:25]);
      step(6);
      check({gate_on, drive_en, force_low, pwr_down} == e[24:0], "R2-table vector",
            {7'd0, gate_on, drive_en, force_low, pwr_down}, {7'd0, e[24:0]});
    end

    // R2: latency of three edges, enable 3 on pad 5 controls lane 6
    restart(4'b1000, 4'b0000, 2'd0, 1'b0, 1'b0, 8'd0, 8'hFF);
    step(4);
    pin_in[5] = 1'b0;
    step(2);
    check(gate_on[6] == 1'b1, "R2 still open after 2 edges", gate_on, 8'hDF);
    step(1);
    check(gate_on == 8'h9F, "R2 closed after 3rd edge", gate_on, 8'h9F);
    pin_in[5] = 1'b1;
    step(3);
    check(gate_on == 8'hDF, "R2 reopen", gate_on, 8'hDF);

    // R7: gate waits for the lane clock to be low
    restart(4'b0100, 4'b0000, 2'd0, 1'b0, 1'b0, 8'd0, 8'hFF);
    step(4);
    check(gate_on == 8'hF7, "R8 pad3 input", gate_on, 8'hF7);
    ch_clk[4] = 1'b1;
    pin_in[3] = 1'b0;
    step(5);
    check(gate_on[4] == 1'b1, "R7 held while clock high", gate_on, 8'hF7);
    ch_clk[4] = 1'b0;
    step(1);
    check(gate_on == 8'hE7, "R7 closes on low clock", gate_on, 8'hE7);

    // R5: power-down closes even with clocks high
    restart(4'b0000, 4'b0000, 2'd2, 1'b0, 1'b0, 8'd0, 8'h40);
    step(4);
    ch_clk = 8'hFF;
    pin_in[6] = 1'b0;
    step(2);
    check(pwr_down && gate_on == 8'hBF, "R5 pwr_down after 2 edges",
          {gate_on, 7'd0, pwr_down}, {8'hBF, 8'h01});
    step(1);
    check(gate_on == 8'h00 && drive_en == 8'h00, "R5 closed with clock high",
          {gate_on, drive_en}, 16'h0);

    // R6: settle hold-off of 5 cycles
    restart(4'b0000, 4'b0000, 2'd2, 1'b0, 1'b1, 8'd5, 8'h00);
    step(4);
    check(pwr_down && drive_en == 8'hBF && force_low == 8'hBF, "R5 low style",
          {drive_en, force_low}, 16'hBFBF);
    pin_in[6] = 1'b1;
    step(2);
    check(!pwr_down, "R6 pwr_down released", pwr_down, 1'b0);
    step(5);
    check(gate_on == 8'h00 && force_low == 8'hBF, "R6 hold at edge 5",
          {gate_on, force_low}, 16'h00BF);
    step(1);
    check(gate_on == 8'hBF && drive_en == 8'hBF && force_low == 8'h00, "R6 open at edge 6",
          {gate_on, drive_en, force_low}, {8'hBF, 8'hBF, 8'h00});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule